// File: doc/BRIEF.md
# NAND Bus Cycle Sequencer

This block sits on the host side of an 8-bit multiplexed NAND flash bus and turns one request into the full strobe sequence for a single-page read or a single-page program. A request carries the operation, a row address, a starting column and a byte count. For a program, the payload arrives on a separate valid/ready byte stream. The block produces chip enable, the command and address latch qualifiers, the write and read strobes, and the output-enable for the shared data lines. It then waits on the device ready/busy line before it returns read bytes or signals completion.

Every timing figure is a clock-cycle parameter: write-strobe low and high widths, read-strobe low and high widths, the delay before busy is watched, the minimum spacing between the last address strobe and the first payload strobe, and a busy timeout. The ready/busy line is the only completion indication the block trusts. It passes through a synchronizer before use. If the device stays busy too long, the operation ends with an error and the block returns to idle.

Top module: `nand_seq`

## Requirements
- R1: A command cycle holds `nand_cle` high and `nand_ale` low across one write-strobe pulse (low for `T_WP` cycles). A read uses opcode 0x00 then 0x30. A program uses opcode 0x80 then 0x10. The opcode is driven on `nand_dq_o[7:0]`.
- R2: Each address cycle holds `nand_ale` high and `nand_cle` low. `COL_BYTES` column bytes go first, then `ROW_BYTES` row bytes, each value least significant byte first and zero-extended. With the defaults, the bytes are col[7:0], col[11:8], row[7:0], row[15:8], row[17:16].
- R3: `nand_dq_o`, `nand_cle` and `nand_ale` do not change in the cycle where `nand_we_n` rises.
- R4: `nand_we_n` and `nand_re_n` are never low together. `nand_ce_n` stays low from acceptance until the completion pulse, then returns high.
- R5: `nand_dq_oe` is high at every write-strobe rising edge. It is low whenever `nand_re_n` is low and while idle.
- R6: In a program, at least `T_ADL` cycles separate the rising write strobe of the last address byte from the rising write strobe of the first payload byte.
- R7: A read returns `req_cnt`+1 bytes, after ready/busy has been seen high. It uses exactly that many read-strobe pulses. Each byte is sampled after `T_REA` cycles of strobe low and presented with a one-cycle `rd_valid`.
- R8: A program writes `req_cnt`+1 payload bytes, taken from the stream in arrival order; a byte is taken when `wr_valid` and `wr_ready` are both high. It then issues the confirm opcode and completes once ready/busy returns high.
- R9: `req_ready` is low from the cycle after acceptance until the cycle of the completion pulse `done`.
- R10: If ready/busy stays low for `BUSY_TIMEOUT` cycles, the block pulses `done` with `err` high and returns to idle. No read strobe is issued. `err` is low on every normal completion.
- R11: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale` and `nand_dq_oe` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 1 | 0 = page read, 1 = page program |
| req_row | input | ROW_W | Page (row) address |
| req_col | input | COL_W | Starting column |
| req_cnt | input | LEN_W | Byte count minus one |
| wr_valid | input | 1 | Payload byte offered |
| wr_ready | output | 1 | Payload byte taken when high with wr_valid |
| wr_data | input | 8 | Payload byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch qualifier |
| nand_ale | output | 1 | Address latch qualifier |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Outgoing bus byte |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Incoming bus byte |
| nand_rb | input | 1 | Ready (high) / busy (low) |

## Verification
A wrong internal state would show at the ports within one strobe pulse. A misplaced address counter gives a wrong or missing address byte before the confirm opcode. A state that skips the spacing window pulls the first payload strobe closer than `T_ADL` to the last address strobe. An off-by-one byte index shows up as an extra or missing read-strobe pulse, or an extra or missing payload byte, in the same operation. A lost busy watch shows up as read strobes while ready/busy is still low, or as a completion that never arrives before the timeout.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_GAP,
    ST_WFETCH,
    ST_WDATA,
    ST_WB,
    ST_BUSY,
    ST_RDATA,
    ST_DONE
  } seq_state_t;

  localparam logic [7:0] OPC_RD_SETUP = 8'h00;
  localparam logic [7:0] OPC_RD_GO    = 8'h30;
  localparam logic [7:0] OPC_PG_SETUP = 8'h80;
  localparam logic [7:0] OPC_PG_GO    = 8'h10;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/nand_seq_addr.sv
module nand_seq_addr #(
  parameter int COL_W     = 12,
  parameter int ROW_W     = 18,
  parameter int COL_BYTES = 2,
  parameter int ROW_BYTES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  output logic [7:0]       byte_o
);
  localparam int CB = 8 * COL_BYTES;
  localparam int RB = 8 * ROW_BYTES;

  logic [CB-1:0]    col_x;
  logic [RB-1:0]    row_x;
  logic [CB+RB-1:0] sr;

  always_comb begin
    col_x = '0;
    col_x[COL_W-1:0] = col;
    row_x = '0;
    row_x[ROW_W-1:0] = row;
  end

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= {row_x, col_x};
    else if (shift) sr <= sr >> 8;
  end

  assign byte_o = sr[7:0];
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int COL_W        = 12,
  parameter int ROW_W        = 18,
  parameter int COL_BYTES    = 2,
  parameter int ROW_BYTES    = 3,
  parameter int LEN_W        = 12,
  parameter int T_WP         = 2,
  parameter int T_WH         = 2,
  parameter int T_ADL        = 13,
  parameter int T_REA        = 3,
  parameter int T_REH        = 2,
  parameter int T_WB         = 4,
  parameter int BUSY_TIMEOUT = 400,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [LEN_W-1:0] req_cnt,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             err,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb
);
  localparam int NADDR    = COL_BYTES + ROW_BYTES;
  localparam int AIW      = $clog2(NADDR + 1);
  localparam int ADL_BASE = T_WH + T_WP + 2;
  localparam int ADL_XTRA = (T_ADL > ADL_BASE) ? (T_ADL - ADL_BASE) : 0;
  localparam int CNT_MAX  = max2(max2(BUSY_TIMEOUT, ADL_XTRA),
                                 max2(max2(T_WP, T_WH), max2(max2(T_REA, T_REH), T_WB)));
  localparam int CW       = $clog2(CNT_MAX + 2);

  seq_state_t       st;
  logic [CW-1:0]    cnt;
  logic             low;
  logic             confirm;
  logic             op_q;
  logic             tmo;
  logic [LEN_W-1:0] n_q;
  logic [LEN_W-1:0] idx;
  logic [AIW-1:0]   acnt;
  logic             rb_s;
  logic             a_load;
  logic             a_shift;
  logic [7:0]       a_byte;
  logic             tick;

  nand_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (nand_rb),
    .q   (rb_s)
  );

  nand_seq_addr #(
    .COL_W     (COL_W),
    .ROW_W     (ROW_W),
    .COL_BYTES (COL_BYTES),
    .ROW_BYTES (ROW_BYTES)
  ) u_addr (
    .clk    (clk),
    .rst    (rst),
    .load   (a_load),
    .shift  (a_shift),
    .col    (req_col),
    .row    (req_row),
    .byte_o (a_byte)
  );

  assign tick     = (cnt == '0);
  assign a_load   = (st == ST_IDLE) && req_valid;
  assign a_shift  = tick && !low &&
                    (((st == ST_CMD) && !confirm) || ((st == ST_ADDR) && (acnt != '0)));
  assign wr_ready = (st == ST_WFETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      low        <= 1'b0;
      confirm    <= 1'b0;
      op_q       <= 1'b0;
      tmo        <= 1'b0;
      n_q        <= '0;
      idx        <= '0;
      acnt       <= '0;
      req_ready  <= 1'b1;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      nand_ce_n  <= 1'b1;
      nand_cle   <= 1'b0;
      nand_ale   <= 1'b0;
      nand_we_n  <= 1'b1;
      nand_re_n  <= 1'b1;
      nand_dq_o  <= '0;
      nand_dq_oe <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      if (!tick) cnt <= cnt - 1'b1;

      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            op_q       <= req_op;
            n_q        <= req_cnt;
            idx        <= '0;
            tmo        <= 1'b0;
            confirm    <= 1'b0;
            req_ready  <= 1'b0;
            nand_ce_n  <= 1'b0;
            nand_cle   <= 1'b1;
            nand_dq_o  <= req_op ? OPC_PG_SETUP : OPC_RD_SETUP;
            nand_dq_oe <= 1'b1;
            nand_we_n  <= 1'b0;
            low        <= 1'b1;
            cnt        <= CW'(T_WP - 1);
            st         <= ST_CMD;
          end
        end

        ST_CMD: begin
          if (tick && low) begin
            nand_we_n <= 1'b1;
            low       <= 1'b0;
            cnt       <= CW'(T_WH - 1);
          end else if (tick) begin
            nand_cle <= 1'b0;
            if (!confirm) begin
              nand_ale  <= 1'b1;
              nand_dq_o <= a_byte;
              nand_we_n <= 1'b0;
              low       <= 1'b1;
              cnt       <= CW'(T_WP - 1);
              acnt      <= AIW'(NADDR - 1);
              st        <= ST_ADDR;
            end else begin
              nand_dq_oe <= 1'b0;
              cnt        <= CW'(T_WB);
              st         <= ST_WB;
            end
          end
        end

        ST_ADDR: begin
          if (tick && low) begin
            nand_we_n <= 1'b1;
            low       <= 1'b0;
            cnt       <= CW'(T_WH - 1);
          end else if (tick) begin
            if (acnt != '0) begin
              nand_dq_o <= a_byte;
              nand_we_n <= 1'b0;
              low       <= 1'b1;
              cnt       <= CW'(T_WP - 1);
              acnt      <= acnt - 1'b1;
            end else begin
              nand_ale <= 1'b0;
              if (!op_q) begin
                nand_cle  <= 1'b1;
                nand_dq_o <= OPC_RD_GO;
                nand_we_n <= 1'b0;
                low       <= 1'b1;
                confirm   <= 1'b1;
                cnt       <= CW'(T_WP - 1);
                st        <= ST_CMD;
              end else begin
                cnt <= CW'(ADL_XTRA);
                st  <= ST_GAP;
              end
            end
          end
        end

        ST_GAP: begin
          if (tick) st <= ST_WFETCH;
        end

        ST_WFETCH: begin
          if (wr_valid) begin
            nand_dq_o <= wr_data;
            nand_we_n <= 1'b0;
            low       <= 1'b1;
            cnt       <= CW'(T_WP - 1);
            st        <= ST_WDATA;
          end
        end

        ST_WDATA: begin
          if (tick && low) begin
            nand_we_n <= 1'b1;
            low       <= 1'b0;
            cnt       <= CW'(T_WH - 1);
          end else if (tick) begin
            if (idx == n_q) begin
              nand_cle  <= 1'b1;
              nand_dq_o <= OPC_PG_GO;
              nand_we_n <= 1'b0;
              low       <= 1'b1;
              confirm   <= 1'b1;
              cnt       <= CW'(T_WP - 1);
              st        <= ST_CMD;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_WFETCH;
            end
          end
        end

        ST_WB: begin
          if (tick) begin
            cnt <= CW'(BUSY_TIMEOUT - 1);
            st  <= ST_BUSY;
          end
        end

        ST_BUSY: begin
          if (rb_s) begin
            if (!op_q) begin
              nand_re_n <= 1'b0;
              low       <= 1'b1;
              cnt       <= CW'(T_REA - 1);
              st        <= ST_RDATA;
            end else begin
              st <= ST_DONE;
            end
          end else if (tick) begin
            tmo <= 1'b1;
            st  <= ST_DONE;
          end
        end

        ST_RDATA: begin
          if (tick && low) begin
            rd_data   <= nand_dq_i;
            rd_valid  <= 1'b1;
            nand_re_n <= 1'b1;
            low       <= 1'b0;
            cnt       <= CW'(T_REH - 1);
          end else if (tick) begin
            if (idx == n_q) begin
              st <= ST_DONE;
            end else begin
              idx       <= idx + 1'b1;
              nand_re_n <= 1'b0;
              low       <= 1'b1;
              cnt       <= CW'(T_REA - 1);
            end
          end
        end

        ST_DONE: begin
          done       <= 1'b1;
          err        <= tmo;
          req_ready  <= 1'b1;
          nand_ce_n  <= 1'b1;
          nand_dq_oe <= 1'b0;
          st         <= ST_IDLE;
        end

        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int T_ADL = 13
) (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       done,
  input logic       err,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic [7:0] nand_dq_o,
  input logic       nand_dq_oe
);
  logic        we_q;
  logic        after_addr;
  logic [15:0] since;
  logic        we_rise;

  assign we_rise = nand_we_n && !we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q       <= 1'b1;
      after_addr <= 1'b0;
      since      <= '0;
    end else begin
      we_q <= nand_we_n;
      if (since != 16'hFFFF) since <= since + 1'b1;
      if (we_rise && nand_ale) begin
        after_addr <= 1'b1;
        since      <= 16'd1;
      end else if (we_rise) begin
        after_addr <= 1'b0;
      end
    end
  end

  a_r1_cle_ale_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  a_r4_we_re_apart: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

  a_r5_release_in_read: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !nand_dq_oe);

  a_r5_drive_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n) |-> nand_dq_oe);

  a_r3_hold_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(nand_we_n) |-> ($stable(nand_dq_o) && $stable(nand_cle) && $stable(nand_ale)));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !nand_ce_n |-> !req_ready);

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  a_r6_adl_spacing: assert property (@(posedge clk) disable iff (rst)
    (we_rise && after_addr && !nand_cle && !nand_ale) |-> (since >= 16'(T_ADL)));
endmodule

bind nand_seq nand_seq_chk #(.T_ADL(T_ADL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .done       (done),
  .err        (err),
  .nand_ce_n  (nand_ce_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_o  (nand_dq_o),
  .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_seq_test.sv
`timescale 1ns/1ps
module nand_seq_test;
  localparam int T_ADL = 13;
  localparam int TMO   = 400;
  localparam int WDOG  = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_op = 1'b0;
  logic [17:0] req_row = '0;
  logic [11:0] req_col = '0;
  logic [11:0] req_cnt = '0;
  logic        wr_valid, wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid, done, err;
  logic [7:0]  rd_data;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rb = 1'b1;

  nand_seq #(.T_ADL(T_ADL), .BUSY_TIMEOUT(TMO)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_row(req_row), .req_col(req_col), .req_cnt(req_cnt),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // payload stream
  logic       stall = 1'b0;
  logic       wclr  = 1'b0;
  logic [7:0] seed  = '0;
  int         wsent = 0;
  always @(posedge clk) begin
    if (wclr) wsent <= 0;
    else if (wr_valid && wr_ready) wsent <= wsent + 1;
  end
  function automatic logic [7:0] pay(input int i, input logic [7:0] s);
    return 8'(i * 29 + 60) ^ s;
  endfunction
  assign wr_valid = !stall || (cyc % 4 != 0);
  assign wr_data  = pay(wsent, seed);

  function automatic logic [7:0] page(input int r, input int c);
    return 8'(r * 7 + c * 3 + 5);
  endfunction

  // flash bus model
  logic [7:0] cmd_log [4];
  logic [7:0] adr_log [8];
  logic [7:0] wd_log  [256];
  logic [7:0] rd_log  [256];
  int ncmd, nadr, nwd, nrd, nre;
  int cur_row, cur_col;
  bit go_busy, hold_bad, oe_bad, ovl_bad, rdy_bad, ce_bad, in_op;
  bit done_seen, err_seen;
  time t_addr, t_data;
  bit first_data;
  logic [9:0] snap;

  always @(negedge nand_we_n) snap = {nand_cle, nand_ale, nand_dq_o};

  always @(posedge nand_we_n) begin
    if (!nand_ce_n) begin
      if (snap != {nand_cle, nand_ale, nand_dq_o}) hold_bad = 1;
      if (!nand_dq_oe) oe_bad = 1;
      if (nand_cle) begin
        if (ncmd < 4) cmd_log[ncmd] = nand_dq_o;
        ncmd++;
        if (nand_dq_o == 8'h30 || nand_dq_o == 8'h10) begin
          cur_col = {adr_log[1], adr_log[0]};
          cur_row = {adr_log[4], adr_log[3], adr_log[2]};
          go_busy = 1;
        end
      end else if (nand_ale) begin
        if (nadr < 8) adr_log[nadr] = nand_dq_o;
        nadr++;
        t_addr = $time;
      end else begin
        if (first_data) begin
          t_data = $time;
          first_data = 0;
        end
        wd_log[nwd[7:0]] = nand_dq_o;
        nwd++;
      end
    end
  end

  always @(negedge nand_re_n) begin
    #1;
    nand_dq_i = page(cur_row, cur_col + nre);
    nre++;
  end

  always @(negedge clk) begin
    if (rd_valid) begin
      rd_log[nrd[7:0]] = rd_data;
      nrd++;
    end
    if (done) begin
      done_seen = 1;
      err_seen  = err;
    end
    if (in_op) begin
      if (req_ready && !done) rdy_bad = 1;
      if (!nand_we_n && !nand_re_n) ovl_bad = 1;
      if (nand_ce_n && !done_seen) ce_bad = 1;
      if (!nand_re_n && nand_dq_oe) oe_bad = 1;
    end
  end

  task automatic run_op(input bit op, input int row, input int col, input int cnt,
                        input int busy, input bit stl, input bit hang, input logic [7:0] sd);
    logic [7:0] ea [5];
    int n;
    ncmd = 0; nadr = 0; nwd = 0; nrd = 0; nre = 0;
    go_busy = 0; hold_bad = 0; oe_bad = 0; ovl_bad = 0; rdy_bad = 0; ce_bad = 0;
    done_seen = 0; err_seen = 0; first_data = 1; t_addr = 0; t_data = 0;
    seed = sd; stall = stl; wclr = 1;
    @(negedge clk);
    wclr = 0;
    req_valid = 1; req_op = op; req_row = 18'(row); req_col = 12'(col); req_cnt = 12'(cnt);
    @(negedge clk);
    req_valid = 0;
    in_op = 1;
    while (!go_busy && !done_seen) @(negedge clk);
    nand_rb = 0;
    if (hang) begin
      while (!done_seen) @(negedge clk);
    end else begin
      for (int k = 0; k < busy; k++) @(negedge clk);
    end
    nand_rb = 1;
    while (!done_seen) @(negedge clk);
    in_op = 0;
    @(negedge clk);
    ea[0] = 8'(col); ea[1] = 8'(col >> 8);
    ea[2] = 8'(row); ea[3] = 8'(row >> 8); ea[4] = 8'(row >> 16);
    n = cnt + 1;
    chk(ncmd == 2 && cmd_log[0] == (op ? 8'h80 : 8'h00) && cmd_log[1] == (op ? 8'h10 : 8'h30),
        "R1 opcodes", {cmd_log[0], cmd_log[1]}, op ? 16'h8010 : 16'h0030);
    chk(nadr == 5 && adr_log[0] == ea[0] && adr_log[1] == ea[1] && adr_log[2] == ea[2] &&
        adr_log[3] == ea[3] && adr_log[4] == ea[4], "R2 address bytes", nadr, 5);
    chk(!hold_bad, "R3 hold at strobe rise", hold_bad, 0);
    chk(!ovl_bad && !ce_bad && nand_ce_n, "R4 strobes and enable", {ovl_bad, ce_bad}, 0);
    chk(!oe_bad && !nand_dq_oe, "R5 bus drive", oe_bad, 0);
    chk(!rdy_bad && req_ready, "R9 ready held low", rdy_bad, 0);
    chk(err_seen == hang, "R10 error flag", err_seen, hang);
    if (hang) begin
      chk(nre == 0 && nrd == 0, "R10 no read strobe after timeout", nre, 0);
    end else if (!op) begin
      int mism = 0;
      for (int i = 0; i < n && i < 256; i++) if (rd_log[i] != page(row, col + i)) mism++;
      chk(nre == n, "R7 read strobe count", nre, n);
      chk(nrd == n && mism == 0, "R7 read data", mism, 0);
    end else begin
      int mism = 0;
      for (int i = 0; i < n && i < 256; i++) if (wd_log[i] != pay(i, sd)) mism++;
      chk(nwd == n && mism == 0, "R8 payload bytes", nwd, n);
      chk(t_data - t_addr >= T_ADL * 8, "R6 address-to-data spacing", int'(t_data - t_addr), T_ADL * 8);
    end
  endtask

  // op, row, col, cnt, busy, stall
  localparam int NV = 6;
  localparam logic [62:0] VEC [NV] = '{
    {1'b0, 18'h2A5C3, 12'h000, 12'd3,  12'd20,  8'd0},
    {1'b1, 18'h00017, 12'h7F0, 12'd4,  12'd35,  8'd0},
    {1'b0, 18'h3FFFF, 12'hFFF, 12'd0,  12'd60,  8'd0},
    {1'b1, 18'h10101, 12'h123, 12'd7,  12'd15,  8'd1},
    {1'b0, 18'h00001, 12'h840, 12'd15, 12'd120, 8'd0},
    {1'b1, 18'h3C3C3, 12'h001, 12'd0,  12'd5,   8'd1}
  };

  initial begin
    in_op = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(nand_ce_n && nand_we_n && nand_re_n, "R11 strobes idle high",
        {nand_ce_n, nand_we_n, nand_re_n}, 7);
    chk(!nand_cle && !nand_ale && !nand_dq_oe && req_ready, "R11 qualifiers low, ready high",
        {nand_cle, nand_ale, nand_dq_oe, req_ready}, 1);
    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][62], int'(VEC[v][61:44]), int'(VEC[v][43:32]), int'(VEC[v][31:20]),
             int'(VEC[v][19:8]), VEC[v][0], 1'b0, 8'(v * 17));
    end
    // R10 busy never clears on a read, then a program
    run_op(1'b0, 'h155, 'h10, 2, 0, 1'b0, 1'b1, 8'h00);
    run_op(1'b1, 'h0AA, 'h20, 1, 0, 1'b0, 1'b1, 8'h33);
    // recovery after timeout
    run_op(1'b0, 'h2222, 'h3, 5, 10, 1'b0, 1'b0, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule